// File: doc/BRIEF.md
# Burst-Mode Synchronous Serial Port with Byte Buffer

This block is a clock-synchronous, full-duplex serial port with an eight-entry byte buffer. The host fills the buffer through a small register port, chooses how many bytes to move (one to eight), and issues one start command. The port then shifts every byte out on the serial data output and captures one byte from the serial data input for each byte sent. No further host action is needed. Each captured byte overwrites the buffer slot whose byte has just gone out. When the burst ends, the host reads the answers back in order.

The shift clock is either produced inside the block from the system clock by a programmable divider, or taken from an external pin. Three further options are available. Bit order can be most- or least-significant first. A chip-select mode lets transfers advance only while the active-low select input is low, and stops driving the data output while it is high. A strobe output can pulse once after the final shift-clock rise of a burst.

Register map (2-bit address): 0 = buffer data port (a write stores at the host pointer and advances it, a read strobe advances it); 1 = configuration; 2 = control on write (bit 0 start, bit 1 clear done) and status on read (bit 0 busy, bit 1 done); 3 = shift-clock half period in system clocks.

Top module: `ssp_burst_port`

## Requirements
- R1: After reset the status register reads 0, the divider register reads 4, sck_o is high, lat_o is low, and sck_oe and so_oe are both high.
- R2: A start command moves bytes from buffer slots 0 upward. Output data changes at each falling shift-clock edge, and input data is sampled at each rising edge. With configuration bit 3 at 0, each byte goes most significant bit first in both directions.
- R3: With configuration bit 3 at 1, both the sent and the captured bytes are least significant bit first.
- R4: Configuration bits 2:0 give the byte count, and a value of 0 means 8. A burst produces exactly eight rising shift-clock edges per byte.
- R5: The byte captured while slot k is sent replaces slot k. The host pointer returns to 0 at the end of a burst and on any configuration write, so data-port reads then return the captured bytes in burst order.
- R6: Status bit 0 is high while a burst runs. Status bit 1 goes high when the burst ends and stays high until the host writes control bit 1.
- R7: While a burst or strobe is active, start commands and writes to the data, configuration and divider registers have no effect.
- R8: In internal-clock mode, each half period of sck_o lasts the divider value in system clocks (0 acts as 1), and sck_o rests high outside a burst.
- R9: With configuration bit 4 at 1, the shift clock comes from sck_i, sck_oe is low, and a burst completes on external edges alone.
- R10: With configuration bit 5 at 1, shift-clock edges are ignored and so_oe is low while cs_n is high.
- R11: With configuration bit 6 at 1, lat_o goes high at the clock edge that brings the final shift-clock rise of a burst into effect. It stays high for twice the divider value in system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the host pointer on address 0) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| sck_i | input | 1 | External shift clock |
| sck_o | output | 1 | Generated shift clock |
| sck_oe | output | 1 | Drive enable for sck_o (high in internal-clock mode) |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |
| so_oe | output | 1 | Drive enable for so (low while deselected in chip-select mode) |
| cs_n | input | 1 | Active-low chip select |
| lat_o | output | 1 | Post-burst latch strobe |

## Verification
The bench uses a serial peer model that answers with its own byte stream and rebuilds what the port sends. A port with the bit order reversed, or one that writes captured bytes into the wrong slot, returns mismatched bytes or a scrambled read-back. A count of 0 is driven to confirm that it means eight bytes and not zero or one. A second start and a configuration write are issued mid-burst; a port that honoured them would show extra shift edges or a changed count. In external-clock chip-select mode, full clock bursts are driven while deselected; a port that did not gate on the select line would finish early and capture garbage. The divider and strobe tests measure the actual half period and strobe width, and check that the strobe does not rise before the last shift edge.

// File: rtl/ssp_pkg.sv
// Package: shared register addresses for the burst serial port.
// Assumes a 2-bit register address bus.
package ssp_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_CFG  = 2'd1,
        REG_CTRL = 2'd2,
        REG_DIV  = 2'd3
    } reg_addr_e;

    // Replace a zero divider by one so the generator always advances.
    function automatic logic [7:0] eff_div8(input logic [7:0] v);
        return (v == 8'd0) ? 8'd1 : v;
    endfunction
endpackage

// File: rtl/ssp_sck_gen.sv
// Shift-clock source: produces one-cycle rise/fall event pulses either from an
// internal divider (sck_o idles high, first edge is a fall) or from a
// synchronised external clock. Assumes SYNC_STAGES >= 2 and that the
// external clock half period exceeds SYNC_STAGES+1 system clocks.
module ssp_sck_gen #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_clk,
    input  logic [DIV_W-1:0] half_div,
    input  logic             cs_block,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0]       cnt;
    logic                   sck_q;
    logic [SYNC_STAGES-1:0] sck_sync;
    logic                   sck_prev;
    logic [DIV_W-1:0]       half_eff;
    logic                   wrap;
    logic                   m_go;
    logic                   s_go;

    assign half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
    assign wrap     = (cnt == half_eff - DIV_W'(1));
    assign m_go     = run && !ext_clk && !cs_block && wrap;
    assign s_go     = run && ext_clk && !cs_block;

    // Internal divider: count half periods and toggle the clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || ext_clk) begin
            cnt   <= '0;
            sck_q <= 1'b1;
        end else if (!cs_block) begin
            if (wrap) begin
                cnt   <= '0;
                sck_q <= ~sck_q;
            end else begin
                cnt <= cnt + DIV_W'(1);
            end
        end
    end

    // External clock: synchronise and remember the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sync <= '1;
            sck_prev <= 1'b1;
        end else begin
            sck_sync <= {sck_sync[SYNC_STAGES-2:0], sck_i};
            sck_prev <= sck_sync[SYNC_STAGES-1];
        end
    end

    assign rise  = (m_go && !sck_q) || (s_go && sck_sync[SYNC_STAGES-1] && !sck_prev);
    assign fall  = (m_go && sck_q)  || (s_go && !sck_sync[SYNC_STAGES-1] && sck_prev);
    assign sck_o = sck_q;

    // R8: generated clock rests high whenever no burst runs.
    a_r8_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> sck_q);
endmodule

// File: rtl/ssp_fifo.sv
// Byte buffer: DEPTH slots with a host port and an engine port. An engine
// write wins over a host write to the same slot. Assumes the top keeps host
// writes out while a burst runs.
module ssp_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [IDX_W-1:0]  h_idx,
    input  logic [DATA_W-1:0] h_data,
    output logic [DATA_W-1:0] h_q,
    input  logic              e_we,
    input  logic [IDX_W-1:0]  e_idx,
    input  logic [DATA_W-1:0] e_data,
    output logic [DATA_W-1:0] e_q
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // One storage slot, written by the engine or by the host.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[i] <= '0;
            else if (e_we && e_idx == IDX_W'(i))
                slot[i] <= e_data;
            else if (h_we && h_idx == IDX_W'(i))
                slot[i] <= h_data;
        end
    end

    assign h_q = slot[h_idx];
    assign e_q = slot[e_idx];
endmodule

// File: rtl/ssp_shift_engine.sv
// Shift engine: walks the byte and bit counters of a burst. On each fall event
// it presents the next output bit, and on each rise event it samples the input.
// It writes each finished byte back into the slot being sent. Assumes rise and
// fall events alternate, starting with a fall.
module ssp_shift_engine #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3,
    parameter int BIT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W:0]    nbytes,
    input  logic              lsb_first,
    input  logic              rise,
    input  logic              fall,
    input  logic              si_s,
    input  logic              cs_block,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              busy,
    output logic [IDX_W-1:0]  byte_idx,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              finish,
    output logic              so_bit
);
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_next;
    logic              tx_bit;
    logic              last_bit;
    logic              last_byte;

    assign tx_bit    = lsb_first ? tx_byte[bit_idx] : tx_byte[BIT_W'(DATA_W-1) - bit_idx];
    assign rx_next   = lsb_first ? {si_s, rx_sh[DATA_W-1:1]} : {rx_sh[DATA_W-2:0], si_s};
    assign last_bit  = (bit_idx == BIT_W'(DATA_W-1));
    assign last_byte = ({1'b0, byte_idx} == nbytes - (IDX_W+1)'(1));
    assign wr_en     = busy && rise && last_bit;
    assign wr_data   = rx_next;
    assign finish    = wr_en && last_byte;

    // Burst sequencing: counters, output bit and receive shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            bit_idx  <= '0;
            byte_idx <= '0;
            rx_sh    <= '0;
            so_bit   <= 1'b1;
        end else if (!busy) begin
            if (start) begin
                busy     <= 1'b1;
                bit_idx  <= '0;
                byte_idx <= '0;
            end
        end else begin
            if (fall)
                so_bit <= tx_bit;
            if (rise) begin
                rx_sh <= rx_next;
                if (last_bit) begin
                    bit_idx <= '0;
                    if (last_byte)
                        busy <= 1'b0;
                    else
                        byte_idx <= byte_idx + IDX_W'(1);
                end else begin
                    bit_idx <= bit_idx + BIT_W'(1);
                end
            end
        end
    end

    // R4: the byte counter never passes the programmed count.
    a_r4_byte_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, byte_idx} < nbytes));
    // R10: no shift event reaches the engine while deselected.
    a_r10_cs_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        cs_block |-> !(rise || fall));
endmodule

// File: rtl/ssp_burst_port.sv
// Top of the burst serial port: register port, input synchronisers, host
// pointer, done flag and latch strobe around the clock source, buffer and
// shift engine. Assumes DEPTH is a power of two, DATA_W >= IDX_W+4 and
// DATA_W >= DIV_W.
module ssp_burst_port #(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic              cs_n,
    output logic              lat_o
);
    import ssp_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);
    localparam int BIT_W = $clog2(DATA_W);
    localparam int LAT_W = DIV_W + 1;

    logic [IDX_W-1:0]       cfg_cnt;
    logic                   cfg_lsb, cfg_ext, cfg_cs, cfg_lat;
    logic [DIV_W-1:0]       half_div;
    logic [IDX_W-1:0]       hptr;
    logic                   done;
    logic                   lat_q;
    logic [LAT_W-1:0]       lat_cnt;
    logic [SYNC_STAGES-1:0] si_sync, cs_sync;
    logic                   cs_block, busy, active, start;
    logic                   rise, fall, e_we, finish, so_bit;
    logic [IDX_W-1:0]       byte_idx;
    logic [DATA_W-1:0]      e_data, h_q, e_q;
    logic [IDX_W:0]         nbytes;
    logic [DIV_W-1:0]       half_eff;
    logic                   wr_data_reg, rd_data_reg;

    assign cs_block    = cfg_cs && cs_sync[SYNC_STAGES-1];
    assign active      = busy || lat_q;
    assign nbytes      = (cfg_cnt == '0) ? (IDX_W+1)'(DEPTH) : {1'b0, cfg_cnt};
    assign half_eff    = (half_div == '0) ? DIV_W'(1) : half_div;
    assign start       = bus_wr && bus_addr == REG_CTRL && bus_wdata[0] && !active;
    assign wr_data_reg = bus_wr && bus_addr == REG_DATA && !active;
    assign rd_data_reg = bus_rd && bus_addr == REG_DATA && !active;

    // Input synchronisers for serial data and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            si_sync <= '0;
            cs_sync <= '1;
        end else begin
            si_sync <= {si_sync[SYNC_STAGES-2:0], si};
            cs_sync <= {cs_sync[SYNC_STAGES-2:0], cs_n};
        end
    end

    // Host registers: configuration, divider and buffer pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cfg_lat, cfg_cs, cfg_ext, cfg_lsb} <= '0;
            cfg_cnt  <= '0;
            half_div <= DIV_W'(4);
            hptr     <= '0;
        end else if (finish) begin
            hptr <= '0;
        end else if (!active) begin
            if (bus_wr && bus_addr == REG_CFG) begin
                cfg_cnt <= bus_wdata[IDX_W-1:0];
                {cfg_lat, cfg_cs, cfg_ext, cfg_lsb} <= bus_wdata[IDX_W+3:IDX_W];
                hptr    <= '0;
            end else if (bus_wr && bus_addr == REG_DIV) begin
                half_div <= bus_wdata[DIV_W-1:0];
            end else if (wr_data_reg || rd_data_reg) begin
                hptr <= hptr + IDX_W'(1);
            end
        end
    end

    // Completion flag: set at burst end, cleared by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else if (finish)
            done <= 1'b1;
        else if (bus_wr && bus_addr == REG_CTRL && bus_wdata[1])
            done <= 1'b0;
    end

    // Latch strobe: one shift-clock period long after the final rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q   <= 1'b0;
            lat_cnt <= '0;
        end else if (finish && cfg_lat) begin
            lat_q   <= 1'b1;
            lat_cnt <= ({1'b0, half_eff} << 1) - LAT_W'(1);
        end else if (lat_q) begin
            if (lat_cnt == '0)
                lat_q <= 1'b0;
            else
                lat_cnt <= lat_cnt - LAT_W'(1);
        end
    end

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_DATA: bus_rdata = h_q;
            REG_CFG:  bus_rdata = DATA_W'({cfg_lat, cfg_cs, cfg_ext, cfg_lsb, cfg_cnt});
            REG_CTRL: bus_rdata = DATA_W'({done, busy});
            default:  bus_rdata = DATA_W'(half_div);
        endcase
    end

    ssp_sck_gen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_sck (
        .clk(clk), .rst_n(rst_n), .run(busy), .ext_clk(cfg_ext),
        .half_div(half_div), .cs_block(cs_block), .sck_i(sck_i),
        .sck_o(sck_o), .rise(rise), .fall(fall)
    );

    ssp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .h_we(wr_data_reg), .h_idx(hptr), .h_data(bus_wdata), .h_q(h_q),
        .e_we(e_we), .e_idx(byte_idx), .e_data(e_data), .e_q(e_q)
    );

    ssp_shift_engine #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BIT_W(BIT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .nbytes(nbytes),
        .lsb_first(cfg_lsb), .rise(rise), .fall(fall),
        .si_s(si_sync[SYNC_STAGES-1]), .cs_block(cs_block), .tx_byte(e_q),
        .busy(busy), .byte_idx(byte_idx), .wr_en(e_we), .wr_data(e_data),
        .finish(finish), .so_bit(so_bit)
    );

    assign so     = so_bit;
    assign so_oe  = !cs_block;
    assign sck_oe = !cfg_ext;

    // R6: a burst ending always leaves the done flag raised.
    a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R7: configuration cannot move while a burst runs.
    a_r7_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cfg_cnt) && $stable(half_div) && $stable(cfg_lsb)));
    // R11: the strobe never overlaps a running burst.
    a_r11_latch_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        lat_o |-> !busy);
    assign lat_o = lat_q;
endmodule

// File: tb/sim_ssp_burst_port.sv
`timescale 1ns/1ps
module sim_ssp_burst_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sck_i = 1'b1, sck_o, sck_oe, si = 1'b0, so, so_oe, cs_n = 1'b1, lat_o;

    int   n_chk = 0, n_fail = 0;
    bit   finished = 1'b0;

    // peer model
    bit        dev_en = 1'b0, dev_lsb = 1'b0;
    logic [7:0] dev_tx [8];
    logic [7:0] cap [8];
    int        rise_cnt = 0, fall_cnt = 0;
    time       last_rise_t = 0, period_t = 0, lat_rise_t = 0, lat_fall_t = 0;

    always #2.5 clk = ~clk;

    ssp_burst_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .si(si), .so(so),
        .so_oe(so_oe), .cs_n(cs_n), .lat_o(lat_o)
    );

    // Peer: present next bit on each falling generated clock.
    always @(negedge sck_o) if (dev_en) begin
        if (fall_cnt < 64)
            si = dev_lsb ? dev_tx[fall_cnt/8][fall_cnt%8] : dev_tx[fall_cnt/8][7-(fall_cnt%8)];
        fall_cnt++;
    end

    // Peer: capture output bit and time each rising generated clock.
    always @(posedge sck_o) begin
        if (dev_en && rise_cnt < 64)
            cap[rise_cnt/8] = dev_lsb ? {so, cap[rise_cnt/8][7:1]} : {cap[rise_cnt/8][6:0], so};
        period_t    = $time - last_rise_t;
        last_rise_t = $time;
        rise_cnt++;
    end

    always @(posedge lat_o) lat_rise_t = $time;
    always @(negedge lat_o) lat_fall_t = $time;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input bit pop, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = pop; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd2, 1'b0, s);
            if (!s[0]) break;
        end
        repeat (40) @(negedge clk);
    endtask

    task automatic reset_peer(input bit lsb);
        dev_lsb = lsb; rise_cnt = 0; fall_cnt = 0;
        for (int i = 0; i < 8; i++) cap[i] = 8'h00;
    endtask

    // R1 / R8: state straight after reset.
    task automatic t_reset();
        logic [7:0] d;
        rd(2'd2, 1'b0, d); chk("R1 status", d, 0);
        rd(2'd3, 1'b0, d); chk("R1 divider", d, 4);
        chk("R1 sck_o idle high (R8)", sck_o, 1);
        chk("R1 lat_o", lat_o, 0);
        chk("R1 enables", {sck_oe, so_oe}, 2'b11);
    endtask

    // R2 / R5 / R6: master, MSB first, three bytes.
    task automatic t_msb();
        logic [7:0] d;
        logic [7:0] hb [3] = '{8'hA5, 8'h3C, 8'h81};
        dev_tx[0] = 8'h5A; dev_tx[1] = 8'hC3; dev_tx[2] = 8'h7E;
        reset_peer(1'b0); dev_en = 1'b1;
        wr(2'd1, 8'h03);
        for (int i = 0; i < 3; i++) wr(2'd0, hb[i]);
        wr(2'd2, 8'h01);
        rd(2'd2, 1'b0, d); chk("R6 busy during burst", d[0], 1);
        wait_idle();
        for (int i = 0; i < 3; i++) chk("R2 MSB bytes on so", cap[i], hb[i]);
        chk("R4 edges for 3 bytes", rise_cnt, 24);
        for (int i = 0; i < 3; i++) begin rd(2'd0, 1'b1, d); chk("R5 readback order", d, dev_tx[i]); end
        rd(2'd2, 1'b0, d); chk("R6 done set", d, 2);
        wr(2'd2, 8'h02);
        rd(2'd2, 1'b0, d); chk("R6 done cleared", d, 0);
        chk("R8 sck_o high after burst", sck_o, 1);
        dev_en = 1'b0;
    endtask

    // R3: LSB first both ways.
    task automatic t_lsb();
        logic [7:0] d;
        dev_tx[0] = 8'h12; dev_tx[1] = 8'h34;
        reset_peer(1'b1); dev_en = 1'b1;
        wr(2'd1, 8'h0A);
        wr(2'd0, 8'h01); wr(2'd0, 8'h80);
        wr(2'd2, 8'h01);
        wait_idle();
        chk("R3 lsb byte0 out", cap[0], 8'h01);
        chk("R3 lsb byte1 out", cap[1], 8'h80);
        rd(2'd0, 1'b1, d); chk("R3 lsb byte0 in", d, 8'h12);
        rd(2'd0, 1'b1, d); chk("R3 lsb byte1 in", d, 8'h34);
        wr(2'd2, 8'h02);
        dev_en = 1'b0;
    endtask

    // R4 / R7: count 0 means 8, writes during burst ignored.
    task automatic t_full();
        logic [7:0] d;
        for (int i = 0; i < 8; i++) dev_tx[i] = 8'(8'h11 * (i + 1));
        reset_peer(1'b0); dev_en = 1'b1;
        wr(2'd1, 8'h00);
        for (int i = 0; i < 8; i++) wr(2'd0, 8'(8'hF0 + i));
        wr(2'd2, 8'h01);
        repeat (30) @(negedge clk);
        wr(2'd2, 8'h01);
        wr(2'd1, 8'h01);
        wr(2'd3, 8'h09);
        wait_idle();
        chk("R4 count 0 gives 64 edges", rise_cnt, 64);
        chk("R7 second start ignored", fall_cnt, 64);
        rd(2'd1, 1'b0, d); chk("R7 cfg write ignored", d, 8'h00);
        rd(2'd3, 1'b0, d); chk("R7 div write ignored", d, 4);
        for (int i = 0; i < 8; i++) begin rd(2'd0, 1'b1, d); chk("R5 eight bytes back", d, dev_tx[i]); end
        chk("R2 last byte out", cap[7], 8'hF7);
        wr(2'd2, 8'h02);
        dev_en = 1'b0;
    endtask

    // R8 / R11: divider period and latch strobe.
    task automatic t_div_latch();
        dev_tx[0] = 8'h00;
        reset_peer(1'b0); dev_en = 1'b1;
        wr(2'd3, 8'd6);
        wr(2'd1, 8'h41);
        wr(2'd0, 8'h96);
        wr(2'd2, 8'h01);
        wait_idle();
        chk("R8 sck period ns", int'(period_t), 60);
        chk("R11 strobe at last rise", int'(lat_rise_t), int'(last_rise_t));
        chk("R11 strobe width ns", int'(lat_fall_t - lat_rise_t), 60);
        chk("R11 edges before strobe", rise_cnt, 8);
        wr(2'd2, 8'h02);
        wr(2'd3, 8'd4);
        dev_en = 1'b0;
    endtask

    // R9 / R10: external clock with chip select gating.
    task automatic t_slave_cs();
        logic [7:0] d, got;
        logic [7:0] peer = 8'h39;
        got = 8'h00;
        wr(2'd1, 8'h31);
        wr(2'd0, 8'hC6);
        repeat (4) @(negedge clk);
        chk("R9 sck_oe low", sck_oe, 0);
        chk("R10 so floated while deselected", so_oe, 0);
        wr(2'd2, 8'h01);
        for (int b = 0; b < 8; b++) begin
            sck_i = 1'b0; repeat (8) @(negedge clk);
            sck_i = 1'b1; repeat (8) @(negedge clk);
        end
        rd(2'd2, 1'b0, d); chk("R10 edges ignored while cs high", d, 1);
        cs_n = 1'b0; repeat (6) @(negedge clk);
        chk("R10 so driven when selected", so_oe, 1);
        for (int b = 0; b < 8; b++) begin
            sck_i = 1'b0; si = peer[7-b]; repeat (8) @(negedge clk);
            got = {got[6:0], so};
            sck_i = 1'b1; repeat (8) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        chk("R9 byte shifted out", got, 8'hC6);
        rd(2'd2, 1'b0, d); chk("R9 done with external clock", d, 2);
        rd(2'd0, 1'b1, d); chk("R9 byte received", d, 8'h39);
        cs_n = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_msb();
        t_lsb();
        t_full();
        t_div_latch();
        t_slave_cs();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule